// File: doc/BRIEF.md
# Pitch Gain Taming Decision Unit

This block sits in the adaptive-codebook stage of a speech encoder. It decides whether the pitch gain must be limited so that decoding errors cannot build up through the long-term predictor, and it applies that limit. Each input carries four values: an integer pitch lag, a signed fractional lag, the running worst-case excitation error level, and the candidate pitch gain in Q14.

The lag is first rounded toward the fractional part. An offset of 50 then turns it into an index into a small built-in zone table, and the index is clipped so that it never points past the last entry. The table gives a lower and an upper zone search limit. In parallel, the error level is compared with a fixed threshold. When the error is above the threshold, any gain above 0.95 is replaced by 0.95.

All results are registered. They appear one clock after the input strobe, together with a single-cycle valid pulse, and they stay unchanged until the next strobe.

Top module: `pitch_tame_unit`

## Requirements
- R1: While and directly after synchronous reset, `out_valid`, `lag_rounded`, `tab_index`, `zone_lo`, `zone_hi`, `tame_flag` and `gain_out` are all zero.
- R2: `out_valid` is high in the cycle after a cycle in which `in_valid` was sampled high, and low after a cycle in which it was sampled low. Back-to-back strobes give back-to-back results.
- R3: `lag_rounded` equals `lag_int + 1` when `lag_frac` (two's complement) is strictly positive. It equals `lag_int` when `lag_frac` is zero or negative.
- R4: `tab_index` is 0 when `lag_rounded` < 50, and `lag_rounded - 50` otherwise.
- R5: `tab_index` never exceeds TAB_LEN-1 (95 by default). Any larger offset lag reads entry 95.
- R6: Table entry i holds lower limit i/ZONE_SPAN (integer division, ZONE_SPAN = 16) and upper limit min(i/ZONE_SPAN + 1, last zone), where the last zone is 5 by default. `zone_lo` and `zone_hi` show the entry at `tab_index`.
- R7: `tame_flag` is 1 exactly when `err_level` (unsigned 32-bit) is strictly greater than 983040000. An error equal to the threshold leaves the flag at 0.
- R8: `gain_out` is 15565 (0.95 in signed Q14) when `tame_flag` is set and the signed `gain_in` is strictly above 15565. In every other case `gain_out` equals `gain_in`, including a gain exactly at 15565 and negative gains.
- R9: While `in_valid` is low, all result outputs keep their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| lag_int | input | LAG_W (8) | Integer pitch lag |
| lag_frac | input | FRAC_W (3) | Signed fractional lag |
| err_level | input | 32 | Running maximum excitation error, unsigned |
| gain_in | input | 16 | Candidate pitch gain, signed Q14 |
| out_valid | output | 1 | One-cycle result strobe |
| lag_rounded | output | LAG_W+1 (9) | Rounded lag |
| tab_index | output | IDX_W (7) | Clipped zone table index |
| zone_lo | output | ZONE_W (3) | Lower zone search limit |
| zone_hi | output | ZONE_W (3) | Upper zone search limit |
| tame_flag | output | 1 | Taming required |
| gain_out | output | 16 | Gain after clamp, signed Q14 |

## Verification
The bench builds the unit with its default parameters: an 8-bit lag, a 96-entry table and 16-entry zones. With an 8-bit lag, rounded lags up to 256 can be driven, which is well past the last table entry, so the clip path is reached. The width of the rounded-lag output is also checked at its top value. A 96-entry table gives six zones, so the last zone, where the upper limit saturates, can be seen together with ordinary zone boundaries. With 32-bit error levels and 16-bit gains, values exactly at the threshold and exactly at the cap can be driven, as well as values one step to either side of each.

// File: rtl/pitch_tame_pkg.sv
package pitch_tame_pkg;

    localparam int GAIN_W = 16;
    localparam int ERR_W  = 32;

    localparam logic signed [GAIN_W-1:0] GAIN_CAP_Q14 = 16'sd15565;
    localparam logic [ERR_W-1:0]         ERR_LIMIT    = 32'd983040000;

    typedef struct packed {
        logic                     tame;
        logic signed [GAIN_W-1:0] gain;
    } judge_t;

    function automatic int zone_upper(input int idx, input int span, input int last_zone);
        int z;
        z = idx / span + 1;
        return (z > last_zone) ? last_zone : z;
    endfunction

endpackage

// File: rtl/lag_rounder.sv
module lag_rounder #(
    parameter int LAG_W    = 8,
    parameter int FRAC_W   = 3,
    parameter int LAG_BASE = 50,
    parameter int TAB_LEN  = 96,
    parameter int IDX_W    = 7
) (
    input  logic [LAG_W-1:0]         lag_int,
    input  logic signed [FRAC_W-1:0] lag_frac,
    output logic [LAG_W:0]           rounded,
    output logic [IDX_W-1:0]         idx
);
    localparam logic [LAG_W:0] BASE_V = (LAG_W+1)'(LAG_BASE);
    localparam logic [LAG_W:0] LAST_V = (LAG_W+1)'(TAB_LEN - 1);

    logic           frac_up;
    logic [LAG_W:0] offset;

    always_comb begin
        frac_up = (lag_frac > FRAC_W'(0));
        rounded = (LAG_W+1)'(lag_int) + (LAG_W+1)'(frac_up);
        offset  = rounded - BASE_V;
        if (rounded < BASE_V)
            idx = '0;
        else if (offset > LAST_V)
            idx = IDX_W'(LAST_V);
        else
            idx = IDX_W'(offset);
    end

    always_comb begin
        if (rounded >= BASE_V && offset <= LAST_V)
            assert_index_exact_R4: assert (IDX_W'(offset) == idx);
    end
endmodule

// File: rtl/zone_rom.sv
module zone_rom #(
    parameter int TAB_LEN   = 96,
    parameter int ZONE_SPAN = 16,
    parameter int IDX_W     = 7,
    parameter int ZONE_W    = 3
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [ZONE_W-1:0] zone_lo,
    output logic [ZONE_W-1:0] zone_hi
);
    import pitch_tame_pkg::*;

    localparam int LAST_ZONE = (TAB_LEN - 1) / ZONE_SPAN;

    logic [ZONE_W-1:0] lo_tab [TAB_LEN];
    logic [ZONE_W-1:0] hi_tab [TAB_LEN];

    for (genvar i = 0; i < TAB_LEN; i++) begin : g_entry
        assign lo_tab[i] = ZONE_W'(i / ZONE_SPAN);
        assign hi_tab[i] = ZONE_W'(zone_upper(i, ZONE_SPAN, LAST_ZONE));
    end

    always_comb begin
        if (int'(idx) < TAB_LEN) begin
            zone_lo = lo_tab[idx];
            zone_hi = hi_tab[idx];
        end else begin
            zone_lo = lo_tab[TAB_LEN-1];
            zone_hi = hi_tab[TAB_LEN-1];
        end
    end

    always_comb begin
        assert_zone_order_R6: assert (zone_lo <= zone_hi);
    end
endmodule

// File: rtl/taming_judge.sv
module taming_judge
    import pitch_tame_pkg::*;
(
    input  logic [ERR_W-1:0]         err_level,
    input  logic signed [GAIN_W-1:0] gain_in,
    output judge_t                   verdict
);
    always_comb begin
        verdict.tame = (err_level > ERR_LIMIT);
        verdict.gain = gain_in;
        if (verdict.tame && gain_in > GAIN_CAP_Q14)
            verdict.gain = GAIN_CAP_Q14;
    end

    always_comb begin
        if (verdict.tame)
            assert_gain_capped_R8: assert (verdict.gain <= GAIN_CAP_Q14);
    end
endmodule

// File: rtl/pitch_tame_unit.sv
module pitch_tame_unit
    import pitch_tame_pkg::*;
#(
    parameter int LAG_W     = 8,
    parameter int FRAC_W    = 3,
    parameter int LAG_BASE  = 50,
    parameter int TAB_LEN   = 96,
    parameter int ZONE_SPAN = 16,
    localparam int IDX_W    = $clog2(TAB_LEN),
    localparam int ZONE_W   = $clog2((TAB_LEN - 1) / ZONE_SPAN + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [LAG_W-1:0]         lag_int,
    input  logic signed [FRAC_W-1:0] lag_frac,
    input  logic [31:0]              err_level,
    input  logic signed [15:0]       gain_in,
    output logic                     out_valid,
    output logic [LAG_W:0]           lag_rounded,
    output logic [IDX_W-1:0]         tab_index,
    output logic [ZONE_W-1:0]        zone_lo,
    output logic [ZONE_W-1:0]        zone_hi,
    output logic                     tame_flag,
    output logic signed [15:0]       gain_out
);
    logic [LAG_W:0]    rnd_c;
    logic [IDX_W-1:0]  idx_c;
    logic [ZONE_W-1:0] zlo_c, zhi_c;
    judge_t            verdict_c;

    lag_rounder #(
        .LAG_W(LAG_W), .FRAC_W(FRAC_W), .LAG_BASE(LAG_BASE),
        .TAB_LEN(TAB_LEN), .IDX_W(IDX_W)
    ) u_round (
        .lag_int(lag_int), .lag_frac(lag_frac),
        .rounded(rnd_c), .idx(idx_c)
    );

    zone_rom #(
        .TAB_LEN(TAB_LEN), .ZONE_SPAN(ZONE_SPAN),
        .IDX_W(IDX_W), .ZONE_W(ZONE_W)
    ) u_rom (
        .idx(idx_c), .zone_lo(zlo_c), .zone_hi(zhi_c)
    );

    taming_judge u_judge (
        .err_level(err_level), .gain_in(gain_in), .verdict(verdict_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            lag_rounded <= '0;
            tab_index   <= '0;
            zone_lo     <= '0;
            zone_hi     <= '0;
            tame_flag   <= 1'b0;
            gain_out    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                lag_rounded <= rnd_c;
                tab_index   <= idx_c;
                zone_lo     <= zlo_c;
                zone_hi     <= zhi_c;
                tame_flag   <= verdict_c.tame;
                gain_out    <= verdict_c.gain;
            end
        end
    end

    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_fall_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_round_up_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lag_frac > FRAC_W'(0)) |=>
        lag_rounded == (LAG_W+1)'($past(lag_int)) + 1'b1);
    assert_index_bound_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> int'(tab_index) < TAB_LEN);
    assert_no_tame_pass_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && err_level <= ERR_LIMIT) |=> (!tame_flag && gain_out == $past(gain_in)));
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(gain_out) && $stable(tab_index) && $stable(tame_flag)));
endmodule

// File: tb/pitch_tame_unit_tb.sv
module pitch_tame_unit_tb_top;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [7:0]        lag_int = '0;
    logic signed [2:0] lag_frac = '0;
    logic [31:0]       err_level = '0;
    logic signed [15:0] gain_in = '0;
    logic              out_valid;
    logic [8:0]        lag_rounded;
    logic [6:0]        tab_index;
    logic [2:0]        zone_lo, zone_hi;
    logic              tame_flag;
    logic signed [15:0] gain_out;

    int n_tests = 0;
    int n_fail  = 0;

    localparam longint THR = 983040000;
    localparam int     CAP = 15565;

    always #10 clk = ~clk;

    pitch_tame_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .lag_int(lag_int),
        .lag_frac(lag_frac), .err_level(err_level), .gain_in(gain_in),
        .out_valid(out_valid), .lag_rounded(lag_rounded), .tab_index(tab_index),
        .zone_lo(zone_lo), .zone_hi(zone_hi), .tame_flag(tame_flag),
        .gain_out(gain_out)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int e_round(input int t, input int f);
        return (f > 0) ? t + 1 : t;
    endfunction
    function automatic int e_index(input int t0);
        int v;
        v = (t0 < 50) ? 0 : t0 - 50;
        return (v > 95) ? 95 : v;
    endfunction
    function automatic int e_hi(input int i);
        return (i / 16 + 1 > 5) ? 5 : i / 16 + 1;
    endfunction
    function automatic int e_gain(input longint e, input int g);
        return (e > THR && g > CAP) ? CAP : g;
    endfunction

    task automatic drive(input int t, input int f, input longint e, input int g);
        lag_int   = 8'(t);
        lag_frac  = 3'(f);
        err_level = 32'(e);
        gain_in   = 16'(g);
    endtask

    task automatic expect_all(input string req, input int t, input int f, input longint e, input int g);
        int t0, ix;
        t0 = e_round(t, f);
        ix = e_index(t0);
        chk(req, "out_valid", out_valid, 1);
        chk(req, "lag_rounded", lag_rounded, t0);
        chk(req, "tab_index", tab_index, ix);
        chk(req, "zone_lo", zone_lo, ix / 16);
        chk(req, "zone_hi", zone_hi, e_hi(ix));
        chk(req, "tame_flag", tame_flag, (e > THR) ? 1 : 0);
        chk(req, "gain_out", gain_out, e_gain(e, g));
    endtask

    task automatic apply(input string req, input int t, input int f, input longint e, input int g);
        @(negedge clk);
        drive(t, f, e, g);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        expect_all(req, t, f, e, g);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "out_valid", out_valid, 0);
        chk("R1", "lag_rounded", lag_rounded, 0);
        chk("R1", "tab_index", tab_index, 0);
        chk("R1", "zone_hi", zone_hi, 0);
        chk("R1", "tame_flag", tame_flag, 0);
        chk("R1", "gain_out", gain_out, 0);
    endtask

    task automatic t_rounding;
        apply("R3", 80, 1, 0, 1000);
        apply("R3", 80, 0, 0, 1000);
        apply("R3", 80, -1, 0, 1000);
        apply("R3", 80, 2, 0, 1000);
        apply("R3", 80, -2, 0, 1000);
        apply("R3", 255, 1, 0, 1000);
    endtask

    task automatic t_index;
        apply("R4", 20, 0, 0, 0);
        apply("R4", 49, 0, 0, 0);
        apply("R4", 49, 1, 0, 0);
        apply("R4", 50, -1, 0, 0);
        apply("R4", 60, 2, 0, 0);
    endtask

    task automatic t_clip;
        apply("R5", 145, 0, 0, 0);
        apply("R5", 146, 0, 0, 0);
        apply("R5", 200, 1, 0, 0);
        apply("R5", 255, 1, 0, 0);
    endtask

    task automatic t_zones;
        apply("R6", 65, 0, 0, 0);
        apply("R6", 66, 0, 0, 0);
        apply("R6", 129, 0, 0, 0);
        apply("R6", 130, 0, 0, 0);
        apply("R6", 140, 0, 0, 0);
    endtask

    task automatic t_threshold;
        apply("R7", 70, 0, THR, 20000);
        apply("R7", 70, 0, THR + 1, 20000);
        apply("R7", 70, 0, THR - 1, 20000);
        apply("R7", 70, 0, 64'hFFFF_FFFF, 20000);
    endtask

    task automatic t_clamp;
        apply("R8", 90, 0, THR + 5, CAP);
        apply("R8", 90, 0, THR + 5, CAP + 1);
        apply("R8", 90, 0, THR + 5, 32767);
        apply("R8", 90, 0, THR + 5, -20000);
        apply("R8", 90, 0, 0, 32767);
    endtask

    task automatic t_hold;
        apply("R9", 100, 1, THR + 9, 30000);
        @(negedge clk);
        drive(30, 0, 0, -5);
        repeat (3) @(negedge clk);
        chk("R9", "out_valid", out_valid, 0);
        chk("R9", "lag_rounded", lag_rounded, 101);
        chk("R9", "tab_index", tab_index, 51);
        chk("R9", "tame_flag", tame_flag, 1);
        chk("R9", "gain_out", gain_out, CAP);
    endtask

    task automatic t_stream;
        @(negedge clk);
        drive(55, 1, THR + 1, 16000);
        in_valid = 1'b1;
        @(negedge clk);
        drive(120, 0, 7, 16000);
        expect_all("R2", 55, 1, THR + 1, 16000);
        @(negedge clk);
        in_valid = 1'b0;
        expect_all("R2", 120, 0, 7, 16000);
        @(negedge clk);
        chk("R2", "out_valid low", out_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_reset();
        t_rounding();
        t_index();
        t_clip();
        t_zones();
        t_threshold();
        t_clamp();
        t_hold();
        t_stream();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule